// File: doc/BRIEF.md
# Staged Idle Power-Gating Controller

This block governs power residency for an on-core matrix execution unit. It counts the cycles that pass without a unit operation and walks the unit through five residency stages, from fully warm (stage 0) to the coldest (stage 4). Each deeper stage is entered when the idle count crosses the next of four fixed thresholds. When an operation is requested, the controller holds it for the wake-up latency of the stage in force at acceptance, then grants it. After that grant the unit is warm again, and the idle count starts over from zero.

A one-cycle release pulse drives the unit straight to the coldest stage. If a wake-up is already running, the release is held back until that wake-up completes. Because grant timing would otherwise reveal how recently the unit was used, a mode selector can remove that dependence. The unit can be pinned to a chosen stage, kept always warm, kept always cold, or run with a flat latency in which every operation is charged the coldest-stage delay. Wake latency depends only on residency and mode, never on operand data. A power-level code is reported alongside the current stage.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset the unit sits in stage 4 with power level 0, and `op_gnt` is low.
- R2: In natural mode (`mode_i` = 0) the stage equals the number of thresholds TH1..TH4 that the idle count has reached. The idle count is the number of idle clock edges since the last grant, saturating at TH4.
- R3: `pwr_lvl_o` always equals 4 minus `stage_o`, so the level is 4 when warm and 0 when coldest.
- R4: A request is accepted on the first clock edge where `op_req` is high, no wake-up is running and `op_gnt` is low. `op_gnt` then goes high for exactly one cycle, N edges after acceptance. N is the latency parameter LATk of the stage k in force at acceptance.
- R5: An operation requested right after a grant sees stage 0 and is charged LAT0.
- R6: A release pulse sampled while no wake-up is running or starting puts the unit in stage 4 from the next cycle on.
- R7: A release sampled during a wake-up leaves the stage unchanged until the grant. In the grant cycle the unit is in stage 4 instead of stage 0.
- R8: Lock mode (`mode_i` = 1) reports and charges the stage given on `lock_stage_i`. Values above 4 are clamped to 4.
- R9: Warm mode (`mode_i` = 2) always reports stage 0 and charges LAT0. Cold mode (`mode_i` = 3) always reports stage 4 and charges LAT4.
- R10: Flat mode (`mode_i` = 4) charges LAT4 to every operation, whatever the idle history. `stage_o` still follows the natural residency.
- R11: Only one operation is outstanding at a time. A grant is never followed by a second grant in the next cycle, and no request is accepted in a grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | 1 | Operation request, held high until granted |
| op_gnt | output | 1 | One-cycle grant after the wake-up latency |
| release_i | input | 1 | Force the coldest stage |
| mode_i | input | 3 | 0 natural, 1 lock, 2 warm, 3 cold, 4 flat latency |
| lock_stage_i | input | 3 | Stage used in lock mode |
| stage_o | output | 3 | Current residency stage, 0..4 |
| pwr_lvl_o | output | 3 | Power-level code, 4 warm down to 0 cold |

## Verification
A wrong idle count or a wrong threshold compare shows up at `stage_o` and `pwr_lvl_o` in the cycle after the edge where the count crosses a threshold. A reference model compared on every clock catches it within one cycle. A wrong latency sample or a timer off by one moves `op_gnt` by at least a cycle, which shows up at the first grant. A lost or premature pending release shows up as stage 0 instead of 4 in the grant cycle itself.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
   localparam int NSTAGE = 5;
   typedef logic [2:0] stage_t;
   localparam stage_t STG_WARM = 3'd0;
   localparam stage_t STG_COLD = 3'd4;
   typedef enum logic [2:0] {
      MODE_NAT  = 3'd0,
      MODE_LOCK = 3'd1,
      MODE_WARM = 3'd2,
      MODE_COLD = 3'd3,
      MODE_FLAT = 3'd4
   } pg_mode_e;
endpackage

// File: rtl/pgate_stage_map.sv
module pgate_stage_map
   import pgate_pkg::*;
#(
   parameter int CNT_W = 20,
   parameter int unsigned THR [NSTAGE-1] = '{1000, 10000, 100000, 1000000}
) (
   input  logic [CNT_W-1:0] idle_cnt,
   output stage_t           nat_stage
);
   logic [NSTAGE-2:0] hit;

   for (genvar i = 0; i < NSTAGE-1; i++) begin : g_cmp
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THR[i]);
      assign hit[i] = (idle_cnt >= LIMIT);
   end

   always_comb begin
      nat_stage = stage_t'($countones(hit));
   end
endmodule

// File: rtl/pgate_policy.sv
module pgate_policy
   import pgate_pkg::*;
#(
   parameter int LAT_W = 16,
   parameter int unsigned LAT [NSTAGE] = '{50, 600, 6000, 9000, 20000}
) (
   input  logic [2:0]       mode_i,
   input  logic [2:0]       lock_stage_i,
   input  stage_t           nat_stage,
   output stage_t           eff_stage,
   output logic [LAT_W-1:0] lat,
   output logic [2:0]       pwr_lvl
);
   always_comb begin
      case (mode_i)
         MODE_LOCK: eff_stage = (lock_stage_i > STG_COLD) ? STG_COLD : lock_stage_i;
         MODE_WARM: eff_stage = STG_WARM;
         MODE_COLD: eff_stage = STG_COLD;
         default:   eff_stage = nat_stage;
      endcase
   end

   always_comb begin
      lat = LAT_W'(LAT[NSTAGE-1]);
      if (mode_i != MODE_FLAT) begin
         for (int i = 0; i < NSTAGE; i++) begin
            if (eff_stage == stage_t'(i)) lat = LAT_W'(LAT[i]);
         end
      end
   end

   assign pwr_lvl = STG_COLD - eff_stage;
endmodule

// File: rtl/pgate_wake_timer.sv
module pgate_wake_timer #(
   parameter int LAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat,
   output logic             busy,
   output logic             done
);
   logic [LAT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)              remain <= '0;
      else if (start)          remain <= lat;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
   assign done = (remain == LAT_W'(1));
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
   import pgate_pkg::*;
#(
   parameter int unsigned TH1  = 1000,
   parameter int unsigned TH2  = 10000,
   parameter int unsigned TH3  = 100000,
   parameter int unsigned TH4  = 1000000,
   parameter int unsigned LAT0 = 50,
   parameter int unsigned LAT1 = 600,
   parameter int unsigned LAT2 = 6000,
   parameter int unsigned LAT3 = 9000,
   parameter int unsigned LAT4 = 20000,
   parameter int LAT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_req,
   output logic       op_gnt,
   input  logic       release_i,
   input  logic [2:0] mode_i,
   input  logic [2:0] lock_stage_i,
   output logic [2:0] stage_o,
   output logic [2:0] pwr_lvl_o
);
   localparam int CNT_W = $clog2(TH4 + 1);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(TH4);
   localparam int unsigned THR [NSTAGE-1] = '{TH1, TH2, TH3, TH4};
   localparam int unsigned LATS [NSTAGE]  = '{LAT0, LAT1, LAT2, LAT3, LAT4};

   if (!(TH1 > 0 && TH1 < TH2 && TH2 < TH3 && TH3 < TH4)) begin : g_bad_thr
      $error("pgate_ctrl: thresholds must be nonzero and strictly increasing");
   end
   for (genvar k = 0; k < NSTAGE; k++) begin : g_lat_chk
      if (LATS[k] < 1 || LATS[k] >= (64'd1 << LAT_W)) begin : g_bad_lat
         $error("pgate_ctrl: stage latency out of range for LAT_W");
      end
   end

   logic [CNT_W-1:0] idle_cnt;
   logic             rel_pend;
   logic             busy, done, accept;
   stage_t           nat_stage, eff_stage;
   logic [LAT_W-1:0] lat;
   logic [2:0]       pwr_lvl;

   pgate_stage_map #(.CNT_W(CNT_W), .THR(THR)) u_map (
      .idle_cnt (idle_cnt),
      .nat_stage(nat_stage)
   );

   pgate_policy #(.LAT_W(LAT_W), .LAT(LATS)) u_pol (
      .mode_i      (mode_i),
      .lock_stage_i(lock_stage_i),
      .nat_stage   (nat_stage),
      .eff_stage   (eff_stage),
      .lat         (lat),
      .pwr_lvl     (pwr_lvl)
   );

   assign accept = op_req && !busy && !op_gnt;

   pgate_wake_timer #(.LAT_W(LAT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .lat  (lat),
      .busy (busy),
      .done (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_cnt <= CAP;
         op_gnt   <= 1'b0;
         rel_pend <= 1'b0;
      end else begin
         op_gnt <= done;
         if (done) begin
            idle_cnt <= (rel_pend || release_i) ? CAP : '0;
            rel_pend <= 1'b0;
         end else if (busy || accept) begin
            if (release_i) rel_pend <= 1'b1;
         end else if (release_i || idle_cnt == CAP) begin
            idle_cnt <= CAP;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

   assign stage_o   = eff_stage;
   assign pwr_lvl_o = pwr_lvl;
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       op_req,
   input logic       op_gnt,
   input logic       release_i,
   input logic [2:0] mode_i,
   input logic [2:0] stage_o,
   input logic [2:0] pwr_lvl_o,
   input logic       busy,
   input logic       rel_pend
);
   AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      op_gnt |=> !op_gnt); // R4

   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      op_gnt |-> op_req); // R11

   AST_GNT_IDLE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      op_gnt |-> !busy); // R11

   AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 && $stable(mode_i) && !$past(release_i) && !$past(rel_pend))
      |-> (stage_o <= $past(stage_o) + 3'd1)); // R2

   AST_GRANT_WARM: assert property (@(posedge clk) disable iff (!rst_n)
      (op_gnt && mode_i == 3'd0 && $stable(mode_i) && !$past(rel_pend) && !$past(release_i))
      |-> stage_o == 3'd0); // R5

   AST_GRANT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_gnt && mode_i == 3'd0 && $past(rel_pend)) |-> stage_o == 3'd4); // R7

   AST_RELEASE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 && $past(release_i && !busy && !(op_req && !op_gnt)))
      |-> stage_o == 3'd4); // R6

   AST_PWR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_o <= 3'd4) && (pwr_lvl_o <= 3'd4)); // R3
endmodule

bind pgate_ctrl pgate_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_req   (op_req),
   .op_gnt   (op_gnt),
   .release_i(release_i),
   .mode_i   (mode_i),
   .stage_o  (stage_o),
   .pwr_lvl_o(pwr_lvl_o),
   .busy     (busy),
   .rel_pend (rel_pend)
);

// File: tb/pgate_ctrl_tb.sv
module pgate_ctrl_tb;
   localparam int T1 = 8, T2 = 16, T3 = 32, T4 = 64;
   localparam int L0 = 2, L1 = 4, L2 = 6, L3 = 8, L4 = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_req = 1'b0;
   logic       release_i = 1'b0;
   logic [2:0] mode_i = 3'd0;
   logic [2:0] lock_stage_i = 3'd0;
   logic       op_gnt;
   logic [2:0] stage_o, pwr_lvl_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   pgate_ctrl #(.TH1(T1), .TH2(T2), .TH3(T3), .TH4(T4),
                .LAT0(L0), .LAT1(L1), .LAT2(L2), .LAT3(L3), .LAT4(L4),
                .LAT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_gnt(op_gnt),
      .release_i(release_i), .mode_i(mode_i), .lock_stage_i(lock_stage_i),
      .stage_o(stage_o), .pwr_lvl_o(pwr_lvl_o)
   );

   // behavioural reference state
   int  m_idle, m_left, m_busy, m_gnt, m_pend;

   function automatic int nat_of(int idle);
      return (idle >= T1) + (idle >= T2) + (idle >= T3) + (idle >= T4);
   endfunction

   function automatic int stage_of(int idle, int md, int lk);
      if (md == 1) return (lk > 4) ? 4 : lk;
      if (md == 2) return 0;
      if (md == 3) return 4;
      return nat_of(idle);
   endfunction

   function automatic int lat_of(int st, int md);
      int tbl [5] = '{L0, L1, L2, L3, L4};
      if (md == 4) return L4;
      return tbl[st];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = T4; m_left = 0; m_busy = 0; m_gnt = 0; m_pend = 0;
      end else begin
         int was_gnt;
         was_gnt = m_gnt;
         m_gnt = 0;
         if (m_busy != 0) begin
            if (m_left > 1) begin
               m_left--;
               if (release_i) m_pend = 1;
            end else begin
               m_gnt = 1; m_busy = 0; m_left = 0;
               m_idle = (m_pend != 0 || release_i) ? T4 : 0;
               m_pend = 0;
            end
         end else if (op_req && was_gnt == 0) begin
            m_busy = 1;
            m_left = lat_of(stage_of(m_idle, mode_i, lock_stage_i), mode_i);
            if (release_i) m_pend = 1;
         end else begin
            m_idle = release_i ? T4 : ((m_idle + 1 > T4) ? T4 : m_idle + 1);
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         int st;
         st = stage_of(m_idle, mode_i, lock_stage_i);
         check("R2 stage vs model", int'(stage_o), st);
         check("R3 power level", int'(pwr_lvl_o), 4 - st);
         check("R4 grant vs model", int'(op_gnt), m_gnt);
      end
   end

   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // request, measure grant latency, return it
   task automatic do_op(string tag, int exp_lat);
      int k;
      k = 0;
      op_req = 1'b1;
      do begin
         @(negedge clk);
         k++;
      end while (!op_gnt && k < 200);
      check(tag, k - 1, exp_lat);
      @(negedge clk);
      op_req = 1'b0;
      check("R11 single grant pulse", int'(op_gnt), 0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset stage", int'(stage_o), 4);
      check("R1 reset power", int'(pwr_lvl_o), 0);
      check("R1 reset grant", int'(op_gnt), 0);

      do_op("R4 cold latency after reset", L4);
      do_op("R5 back-to-back warm latency", L0);
      wait_n(10);  do_op("R2 stage1 latency", L1);
      wait_n(20);  do_op("R2 stage2 latency", L2);
      wait_n(40);  do_op("R2 stage3 latency", L3);
      wait_n(70);  do_op("R2 stage4 latency", L4);

      // R6: release while idle
      wait_n(2);
      check("R6 warm before release", int'(stage_o), 0);
      release_i = 1'b1;
      @(negedge clk);
      release_i = 1'b0;
      check("R6 stage after release", int'(stage_o), 4);
      do_op("R6 latency after release", L4);

      // R7: release during a stage-2 wake-up
      wait_n(20);
      op_req = 1'b1;
      wait_n(2);
      release_i = 1'b1;
      @(negedge clk);
      release_i = 1'b0;
      check("R7 stage held during wake", int'(stage_o), 2);
      while (!op_gnt) @(negedge clk);
      check("R7 stage at grant", int'(stage_o), 4);
      @(negedge clk);
      op_req = 1'b0;
      check("R7 stage after grant", int'(stage_o), 4);

      // R8: lock mode
      mode_i = 3'd1; lock_stage_i = 3'd3;
      @(negedge clk);
      check("R8 locked stage", int'(stage_o), 3);
      do_op("R8 locked latency", L3);
      do_op("R8 locked latency repeat", L3);
      lock_stage_i = 3'd6;
      @(negedge clk);
      check("R8 clamped stage", int'(stage_o), 4);
      do_op("R8 clamped latency", L4);

      // R9: warm and cold modes
      mode_i = 3'd2;
      wait_n(70);
      check("R9 warm stage", int'(stage_o), 0);
      do_op("R9 warm latency after idle", L0);
      mode_i = 3'd3;
      @(negedge clk);
      check("R9 cold stage", int'(stage_o), 4);
      do_op("R9 cold latency", L4);
      do_op("R9 cold latency repeat", L4);

      // R10: flat latency
      mode_i = 3'd4;
      do_op("R10 flat latency warm", L4);
      check("R10 natural stage reported", int'(stage_o), 0);
      wait_n(20);
      do_op("R10 flat latency stage2", L4);
      wait_n(70);
      do_op("R10 flat latency cold", L4);

      mode_i = 3'd0;
      wait_n(5);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule